// File: doc/BRIEF.md
# Memory Self-Test Control Register Bank

This block is the software-facing control point for built-in self-test of up to 32 independent memory groups. One bit position in every register belongs to one group. Three read-write trigger registers (reset, power-gate enable and setup) drive per-group control lines toward the test engines. Two read-only registers report, per group, whether the test has finished and whether it passed.

Software starts a test on a group by setting that group's bit in all three trigger registers. The group's engine runs and reports completion. The bank then captures the completion flag and the pass/fail result, and holds both. When software clears the group's trigger bits, the bank drops the captured status and the group is ready for the next run. The register window is 64 KB wide and is accessed through a simple single-cycle request bus. Read data is returned one cycle after the request.

Top module: `mtest_ctrl_bank`

## Requirements
- R1: The trigger registers sit at offset 0x00 (reset), 0x04 (power-gate enable) and 0x08 (setup). Each is read-write, bit g belongs to group g, and each drives its per-group output lines from the cycle after the write.
- R2: After a synchronous reset, all five registers read 0 and all trigger output lines are 0.
- R3: A group is armed only while its bit is 1 in all three trigger registers. Engine completion on a group that is not armed sets no status.
- R4: On a clock edge where a group is armed, its done bit is 0 and its engine reports completion, the done bit (offset 0x0C) becomes 1. On that same edge the good bit (offset 0x10) takes the engine result: 1 means pass and 0 means fail.
- R5: A good bit reads 0 whenever its done bit is 0, including while a test is in progress.
- R6: Once latched, done and good hold while the group stays armed, even if the engine's outputs change.
- R7: Clearing any trigger bit of a group clears that group's done and good bits on the next edge. A test whose trigger is cleared before completion leaves done and good at 0.
- R8: Writes to the done and good registers have no effect.
- R9: Any other offset in the window reads 0 and ignores writes. An offset whose two low bits are not 00 is treated as such an offset.
- R10: For each read request, bus_rvalid is 1 in the following cycle. In that cycle, bus_rdata holds the register value as it stood at the request edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte offset within the 64 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| grp_reset | output | 32 | Per-group reset trigger line |
| grp_pwr_en | output | 32 | Per-group power-gate enable trigger line |
| grp_setup | output | 32 | Per-group setup trigger line |
| eng_done | input | 32 | Per-group completion from test engines |
| eng_good | input | 32 | Per-group pass result from test engines |

## Verification
The bench arms groups with trigger patterns that differ per register, so that only the bitwise AND may start a test. A bank that armed on a single trigger, or on any one of the three, would then report completion on the wrong groups. It aborts a run by clearing one trigger before completion, and it toggles the engine outputs after a result is captured. A bank that latched late or kept tracking the engine would show a stale or changed pass flag. It also writes to the read-only status offsets, to unmapped offsets and to misaligned offsets, where a loose decode would corrupt triggers or clear status.

// File: rtl/mtest_pkg.sv
package mtest_pkg;
  localparam logic [15:0] OFF_RST   = 16'h0000;
  localparam logic [15:0] OFF_PWR   = 16'h0004;
  localparam logic [15:0] OFF_SETUP = 16'h0008;
  localparam logic [15:0] OFF_DONE  = 16'h000C;
  localparam logic [15:0] OFF_GOOD  = 16'h0010;

  typedef enum logic [2:0] {
    SEL_RST,
    SEL_PWR,
    SEL_SETUP,
    SEL_DONE,
    SEL_GOOD,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/mtest_regif.sv
module mtest_regif
  import mtest_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int NG = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_rvalid,
  output logic [DW-1:0] bus_rdata,
  output logic [NG-1:0] trig_rst,
  output logic [NG-1:0] trig_pwr,
  output logic [NG-1:0] trig_setup,
  input  logic [NG-1:0] stat_done,
  input  logic [NG-1:0] stat_good
);
  reg_sel_e      sel;
  logic [DW-1:0] rd_mux;
  logic          wr_en;
  logic          rd_en;

  always_comb begin
    if      (bus_addr == AW'(OFF_RST))   sel = SEL_RST;
    else if (bus_addr == AW'(OFF_PWR))   sel = SEL_PWR;
    else if (bus_addr == AW'(OFF_SETUP)) sel = SEL_SETUP;
    else if (bus_addr == AW'(OFF_DONE))  sel = SEL_DONE;
    else if (bus_addr == AW'(OFF_GOOD))  sel = SEL_GOOD;
    else                                 sel = SEL_NONE;
  end

  assign wr_en = bus_valid && bus_write;
  assign rd_en = bus_valid && !bus_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_rst   <= '0;
      trig_pwr   <= '0;
      trig_setup <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_RST:   trig_rst   <= bus_wdata[NG-1:0];
        SEL_PWR:   trig_pwr   <= bus_wdata[NG-1:0];
        SEL_SETUP: trig_setup <= bus_wdata[NG-1:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_RST:   rd_mux[NG-1:0] = trig_rst;
      SEL_PWR:   rd_mux[NG-1:0] = trig_pwr;
      SEL_SETUP: rd_mux[NG-1:0] = trig_setup;
      SEL_DONE:  rd_mux[NG-1:0] = stat_done;
      SEL_GOOD:  rd_mux[NG-1:0] = stat_good;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_mux;
    end
  end

  // R10
  rvalid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> bus_rvalid);

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && sel == SEL_NONE) |=> (bus_rdata == '0));

  // R8
  ro_write_keeps_trig_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (sel == SEL_DONE || sel == SEL_GOOD || sel == SEL_NONE))
      |=> ($stable(trig_rst) && $stable(trig_pwr) && $stable(trig_setup)));
endmodule

// File: rtl/mtest_grp_status.sv
module mtest_grp_status (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic eng_done,
  input  logic eng_good,
  output logic done_q,
  output logic good_q
);
  always_ff @(posedge clk) begin
    if (rst || !armed) begin
      done_q <= 1'b0;
      good_q <= 1'b0;
    end else if (!done_q && eng_done) begin
      done_q <= 1'b1;
      good_q <= eng_good;
    end
  end

  // R5
  good_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    good_q |-> done_q);

  // R4
  latch_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !done_q && eng_done) |=> (done_q && good_q == $past(eng_good)));

  // R6
  hold_while_armed_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && done_q) |=> (done_q && $stable(good_q)));

  // R7
  clear_on_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |=> (!done_q && !good_q));
endmodule

// File: rtl/mtest_ctrl_bank.sv
module mtest_ctrl_bank #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int NG = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_rvalid,
  output logic [DW-1:0] bus_rdata,
  output logic [NG-1:0] grp_reset,
  output logic [NG-1:0] grp_pwr_en,
  output logic [NG-1:0] grp_setup,
  input  logic [NG-1:0] eng_done,
  input  logic [NG-1:0] eng_good
);
  logic [NG-1:0] stat_done;
  logic [NG-1:0] stat_good;
  logic [NG-1:0] armed;

  mtest_regif #(.AW(AW), .DW(DW), .NG(NG)) u_regif (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rvalid (bus_rvalid),
    .bus_rdata  (bus_rdata),
    .trig_rst   (grp_reset),
    .trig_pwr   (grp_pwr_en),
    .trig_setup (grp_setup),
    .stat_done  (stat_done),
    .stat_good  (stat_good)
  );

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign armed[g] = grp_reset[g] & grp_pwr_en[g] & grp_setup[g];

    mtest_grp_status u_stat (
      .clk      (clk),
      .rst      (rst),
      .armed    (armed[g]),
      .eng_done (eng_done[g]),
      .eng_good (eng_good[g]),
      .done_q   (stat_done[g]),
      .good_q   (stat_good[g])
    );
  end

  // R3
  done_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat_done & ~$past(armed)) == '0));
endmodule

// File: tb/mtest_ctrl_bank_test.sv
module mtest_ctrl_bank_test;
  localparam int NG = 32;
  localparam logic [15:0] A_RST = 16'h0000, A_PWR = 16'h0004, A_SET = 16'h0008,
                          A_DONE = 16'h000C, A_GOOD = 16'h0010;

  // each entry: {reset, pwr_en, setup, fail_mask}
  localparam logic [127:0] VEC [6] = '{
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {32'h0000_0001, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000},
    {32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000},
    {32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h00FF_FF00, 32'h5555_AAAA},
    {32'hA5A5_A5A5, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 32'h0000_FFFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_rvalid;
  logic [31:0] bus_rdata;
  logic [NG-1:0] grp_reset, grp_pwr_en, grp_setup, eng_done, eng_good;

  logic manual = 1'b0;
  logic [NG-1:0] m_done = '0, m_good = '0, fail_mask = '0, a_done;
  int unsigned cnt [NG];
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  mtest_ctrl_bank uut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .grp_reset(grp_reset), .grp_pwr_en(grp_pwr_en),
    .grp_setup(grp_setup), .eng_done(eng_done), .eng_good(eng_good)
  );

  // behavioural engine stand-in: finishes 4 + g%8 cycles after arming
  wire [NG-1:0] arm_seen = grp_reset & grp_pwr_en & grp_setup;
  always @(posedge clk) begin
    for (int g = 0; g < NG; g++) begin
      if (!arm_seen[g]) begin
        cnt[g] <= 0;
        a_done[g] <= 1'b0;
      end else if (cnt[g] == 4 + (g % 8)) begin
        a_done[g] <= 1'b1;
      end else begin
        cnt[g] <= cnt[g] + 1;
      end
    end
  end
  assign eng_done = manual ? m_done : a_done;
  assign eng_good = manual ? m_good : ~fail_mask;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    check("R10 rvalid", {31'b0, bus_rvalid}, 32'd1);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [31:0] v, armm;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2 reset state
    check("R2 grp_reset", grp_reset, 32'h0);
    check("R2 grp_pwr_en", grp_pwr_en, 32'h0);
    check("R2 grp_setup", grp_setup, 32'h0);
    check("R10 rvalid idle", {31'b0, bus_rvalid}, 32'd0);
    rd(A_RST, v);  check("R2 reset reg", v, 32'h0);
    rd(A_PWR, v);  check("R2 pwr reg", v, 32'h0);
    rd(A_SET, v);  check("R2 setup reg", v, 32'h0);
    rd(A_DONE, v); check("R2 done reg", v, 32'h0);
    rd(A_GOOD, v); check("R2 good reg", v, 32'h0);

    // vector table walk
    foreach (VEC[i]) begin
      fail_mask = VEC[i][31:0];
      armm = VEC[i][127:96] & VEC[i][95:64] & VEC[i][63:32];
      wr(A_RST, VEC[i][127:96]);
      wr(A_PWR, VEC[i][95:64]);
      wr(A_SET, VEC[i][63:32]);
      check("R1 reset line", grp_reset, VEC[i][127:96]);
      check("R1 pwr line", grp_pwr_en, VEC[i][95:64]);
      check("R1 setup line", grp_setup, VEC[i][63:32]);
      rd(A_GOOD, v); check("R5 good in progress", v, 32'h0);
      rd(A_DONE, v); check("R5 done in progress", v, 32'h0);
      idle(20);
      rd(A_RST, v);  check("R1 reset readback", v, VEC[i][127:96]);
      rd(A_PWR, v);  check("R1 pwr readback", v, VEC[i][95:64]);
      rd(A_SET, v);  check("R1 setup readback", v, VEC[i][63:32]);
      rd(A_DONE, v); check("R3 R4 done", v, armm);
      rd(A_GOOD, v); check("R4 good", v, armm & ~fail_mask);
      wr(A_RST, 32'h0); wr(A_PWR, 32'h0); wr(A_SET, 32'h0);
      rd(A_DONE, v); check("R7 done cleared", v, 32'h0);
      rd(A_GOOD, v); check("R7 good cleared", v, 32'h0);
    end

    // directed: manual engine control
    manual = 1'b1; m_done = '0; m_good = '0;

    // R3 partial arm with engine completion present
    m_done[1] = 1'b1; m_good[1] = 1'b1;
    wr(A_RST, 32'h2); wr(A_PWR, 32'h2); wr(A_SET, 32'h0);
    idle(3);
    rd(A_DONE, v); check("R3 partial arm done", v, 32'h0);
    rd(A_GOOD, v); check("R3 partial arm good", v, 32'h0);
    wr(A_RST, 32'h0); wr(A_PWR, 32'h0);
    m_done = '0; m_good = '0;

    // R7 abort before completion
    wr(A_RST, 32'h2); wr(A_PWR, 32'h2); wr(A_SET, 32'h2);
    idle(2);
    wr(A_SET, 32'h0);
    m_done[1] = 1'b1; m_good[1] = 1'b1;
    idle(3);
    rd(A_DONE, v); check("R7 abort done", v, 32'h0);
    rd(A_GOOD, v); check("R7 abort good", v, 32'h0);
    wr(A_RST, 32'h0); wr(A_PWR, 32'h0);
    m_done = '0; m_good = '0;

    // R5 good stays 0 while armed without completion
    wr(A_RST, 32'h1); wr(A_PWR, 32'h1); wr(A_SET, 32'h1);
    m_good[0] = 1'b1;
    idle(3);
    rd(A_GOOD, v); check("R5 good before done", v, 32'h0);

    // R4/R6 one-cycle completion pulse, then engine outputs change
    @(negedge clk); m_done[0] = 1'b1;
    @(negedge clk); m_done[0] = 1'b0; m_good[0] = 1'b0;
    idle(2);
    rd(A_DONE, v); check("R4 pulse done", v, 32'h1);
    rd(A_GOOD, v); check("R4 pulse good", v, 32'h1);
    m_done[0] = 1'b1;
    idle(3);
    rd(A_GOOD, v); check("R6 good held", v, 32'h1);
    rd(A_DONE, v); check("R6 done held", v, 32'h1);

    // R8 writes to status registers ignored
    wr(A_DONE, 32'h0);
    wr(A_GOOD, 32'hFFFF_FFFF);
    rd(A_DONE, v); check("R8 done after write", v, 32'h1);
    rd(A_GOOD, v); check("R8 good after write", v, 32'h1);

    // R9 unmapped and misaligned offsets
    wr(16'h0014, 32'hFFFF_FFFF);
    wr(16'hFFFC, 32'hFFFF_FFFF);
    wr(16'h0001, 32'hFFFF_FFFF);
    wr(16'h0006, 32'hFFFF_FFFF);
    rd(A_RST, v); check("R9 reset unchanged", v, 32'h1);
    rd(A_PWR, v); check("R9 pwr unchanged", v, 32'h1);
    rd(16'h0014, v); check("R9 unmapped read", v, 32'h0);
    rd(16'h0002, v); check("R9 misaligned read", v, 32'h0);
    rd(16'hFFFC, v); check("R9 top read", v, 32'h0);
    rd(A_DONE, v); check("R9 done unchanged", v, 32'h1);

    // R7 clearing one trigger clears status
    wr(A_PWR, 32'h0);
    rd(A_DONE, v); check("R7 done after clear", v, 32'h0);
    rd(A_GOOD, v); check("R7 good after clear", v, 32'h0);

    summary();
  end
endmodule